// File: doc/BRIEF.md
# Register Backup Command Controller

This block starts a copy of the live configuration registers into a nonvolatile backup store. Software starts the copy by writing the global command byte with the backup bit set. The controller takes a snapshot of every register on the cycle it accepts the command. It then holds a busy flag for a fixed, parameterised number of clock cycles, which stands in for the slow program time of the store. At the end of that interval it emits a one-cycle copy-enable with the frozen snapshot.

The supply-good flag is sampled on every busy cycle. If it drops, the copy is abandoned: no copy-enable is issued and an error flag is raised, which stays up until the next accepted request. Each committed copy advances a saturating wear counter that software can read. The command bit is self-clearing, so one write produces at most one backup. Requests that arrive while a copy is in progress are dropped.

Top module: `bkp_ctrl`

## Requirements
- R1: A write strobe whose command byte has bit CMD_BIT (default 3) set, arriving while idle, raises `busy` on the next cycle. A byte with that bit clear has no effect on `busy`, `bkp_we`, `bkp_count` or `bkp_err`, whatever its other bits are.
- R2: `bkp_data` carries the values of `live_regs` sampled at the accepting clock edge. Register `i` occupies bits `[i*REG_W +: REG_W]`. Changes to `live_regs` after that edge do not alter the committed copy.
- R3: With supply good throughout, `busy` stays high for exactly BUSY_CYCLES cycles, then falls.
- R4: `bkp_we` pulses high for one cycle, in the cycle right after `busy` falls on a commit. Each accepted request yields at most one pulse.
- R5: A backup request that arrives while `busy` is high is ignored. It neither extends the busy interval nor adds a pulse or count.
- R6: If `supply_ok` is low at any clock edge while `busy` is high, `busy` falls at that edge, `bkp_we` stays low, `bkp_count` is unchanged and `bkp_err` goes high.
- R7: `bkp_err` stays high until the next accepted request, and it reads low from the cycle after that acceptance.
- R8: `bkp_count` increases by one on each commit, and it shows the new value in the same cycle that `bkp_we` is high.
- R9: `bkp_count` saturates at its all-ones value (CNT_W bits, default 16).
- R10: After reset, `busy`, `bkp_we`, `bkp_err`, `bkp_count` and `bkp_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Single-cycle write strobe for the global command byte |
| cmd_data | input | 8 | Command byte; bit CMD_BIT requests a backup |
| supply_ok | input | 1 | High while the supply voltage is within limits |
| live_regs | input | NUM_REGS*REG_W | Current contents of the user registers, flattened |
| busy | output | 1 | High while a backup is in progress |
| bkp_we | output | 1 | One-cycle copy-enable to the backup array |
| bkp_data | output | NUM_REGS*REG_W | Frozen register snapshot for the backup array |
| bkp_count | output | CNT_W | Count of committed backups, saturating |
| bkp_err | output | 1 | Last backup was abandoned on a supply drop |

## Verification
A wrong busy timer shows up at the ports as a busy window one or more cycles off BUSY_CYCLES, visible the cycle `busy` falls. A snapshot captured at the wrong edge, or not held, shows a `bkp_data` mismatch on the `bkp_we` cycle, because the bench changes `live_regs` right after acceptance. A faulty abort path or counter appears within one cycle of the supply drop or the commit, as a stray pulse, a missing error or a count off by one. A missing saturation shows as a count that wraps to zero on the pulse after the maximum.

// File: rtl/bkp_pkg.sv
package bkp_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } bkp_state_e;

    typedef struct packed {
        bkp_state_e st;
        logic       err;
        logic       we;
    } ctrl_s;

endpackage

// File: rtl/bkp_timer.sv
module bkp_timer #(
    parameter int BUSY_CYCLES = 4_096_000,
    localparam int TW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic done
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = TW'(BUSY_CYCLES - 1);
        else if (tick && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R3: a fresh load always leaves a non-empty window for BUSY_CYCLES > 1
    a_r3_load_window: assert property (@(posedge clk) disable iff (!rst_n)
        (load && BUSY_CYCLES > 1) |=> !done);
endmodule

// File: rtl/bkp_snapshot.sv
module bkp_snapshot #(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 16,
    localparam int TOT_W   = NUM_REGS * REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [TOT_W-1:0] live_i,
    output logic [TOT_W-1:0] snap_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [REG_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (capture) val_d = live_i[g*REG_W +: REG_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign snap_o[g*REG_W +: REG_W] = val_q;
    end
endmodule

// File: rtl/bkp_wear_ctr.sv
module bkp_wear_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != '1) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q == '1) |=> cnt_q == '1);
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != '1) |=> cnt_q == $past(cnt_q) + 1'b1);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q));
endmodule

// File: rtl/bkp_ctrl.sv
module bkp_ctrl
    import bkp_pkg::*;
#(
    parameter int NUM_REGS    = 32,
    parameter int REG_W       = 16,
    parameter int BUSY_CYCLES = 4_096_000,
    parameter int CNT_W       = 16,
    parameter int CMD_BIT     = 3,
    localparam int TOT_W      = NUM_REGS * REG_W,
    localparam int LW         = $clog2(BUSY_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_data,
    input  logic             supply_ok,
    input  logic [TOT_W-1:0] live_regs,
    output logic             busy,
    output logic             bkp_we,
    output logic [TOT_W-1:0] bkp_data,
    output logic [CNT_W-1:0] bkp_count,
    output logic             bkp_err
);
    ctrl_s ctl_d, ctl_q;
    logic  accept;
    logic  commit;
    logic  tmr_done;

    assign accept = cmd_we && cmd_data[CMD_BIT] && (ctl_q.st == ST_IDLE);

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.we = 1'b0;
        commit   = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.st  = ST_BUSY;
                    ctl_d.err = 1'b0;
                end
            end
            ST_BUSY: begin
                if (!supply_ok) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.err = 1'b1;
                end else if (tmr_done) begin
                    ctl_d.st = ST_IDLE;
                    ctl_d.we = 1'b1;
                    commit   = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, err: 1'b0, we: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign busy    = (ctl_q.st == ST_BUSY);
    assign bkp_we  = ctl_q.we;
    assign bkp_err = ctl_q.err;

    bkp_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .tick (busy),
        .done (tmr_done)
    );

    bkp_snapshot #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(accept),
        .live_i (live_regs),
        .snap_o (bkp_data)
    );

    bkp_wear_ctr #(.CNT_W(CNT_W)) u_wear (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (commit),
        .count(bkp_count)
    );

    // Busy-window length tracker used by the window checks below
    logic [LW-1:0] len_d, len_q;
    always_comb begin
        len_d = len_q;
        if (accept)                          len_d = '0;
        else if (busy && len_q != LW'(BUSY_CYCLES)) len_d = len_q + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) len_q <= '0;
        else        len_q <= len_d;
    end

    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_we && cmd_data[CMD_BIT]) |=> busy);
    a_r1_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_we && cmd_data[CMD_BIT])) |=> !busy);
    a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bkp_data));
    a_r3_window: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> len_q < LW'(BUSY_CYCLES));
    a_r3_full_len: assert property (@(posedge clk) disable iff (!rst_n)
        bkp_we |-> len_q == LW'(BUSY_CYCLES));
    a_r4_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bkp_we |=> !bkp_we);
    a_r5_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && supply_ok && !tmr_done) |=> busy);
    a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !supply_ok) |=> (!busy && bkp_err && !bkp_we && $stable(bkp_count)));
    a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_we && cmd_data[CMD_BIT]) |=> !bkp_err);
    a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bkp_err && !(cmd_we && cmd_data[CMD_BIT])) |=> bkp_err);
endmodule

// File: tb/tb_bkp_ctrl.sv
module tb_bkp_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NREG  = 4;
    localparam int RW    = 16;
    localparam int NBUSY = 6;
    localparam int CW    = 4;
    localparam int TW    = NREG * RW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_we = 1'b0;
    logic [7:0]    cmd_data = '0;
    logic          supply_ok = 1'b1;
    logic [TW-1:0] live_regs = '0;
    logic          busy, bkp_we, bkp_err;
    logic [TW-1:0] bkp_data;
    logic [CW-1:0] bkp_count;

    int n_checks = 0;
    int n_fail   = 0;
    int pulses   = 0;
    int exp_cnt  = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bkp_ctrl #(.NUM_REGS(NREG), .REG_W(RW), .BUSY_CYCLES(NBUSY), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .supply_ok(supply_ok), .live_regs(live_regs), .busy(busy),
        .bkp_we(bkp_we), .bkp_data(bkp_data), .bkp_count(bkp_count), .bkp_err(bkp_err)
    );

    always @(negedge clk) if (rst_n && bkp_we) pulses++;

    // vector: [31:24] command byte, [23:20] supply drop at busy cycle (0 none),
    // [16] poke a request at busy cycle 2, [15:0] register seed
    localparam logic [31:0] VEC [8] = '{
        32'h08_0_0_A5A5, 32'h04_0_0_1234, 32'hFF_0_0_0F0F, 32'h08_3_0_BEEF,
        32'h08_0_1_C3C3, 32'h08_6_0_5555, 32'h08_1_0_7E7E, 32'h0C_0_0_9999
    };

    function automatic logic [TW-1:0] pat(input logic [15:0] seed);
        logic [TW-1:0] r;
        for (int i = 0; i < NREG; i++) r[i*RW +: RW] = seed ^ RW'(i * 16'h1111);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_req(input logic [7:0] cmd, input int drop, input bit poke, input logic [15:0] seed);
        int  cyc;
        int  p0;
        bit  err0;
        int  cnt0;
        @(negedge clk);
        err0 = bkp_err; cnt0 = exp_cnt; p0 = pulses;
        live_regs = pat(seed); cmd_we = 1'b1; cmd_data = cmd;
        @(negedge clk);
        cmd_we = 1'b0; live_regs = pat(~seed);
        if (!cmd[3]) begin
            chk(busy == 1'b0, "R1 no start", 64'(busy), 64'd0);
            repeat (NBUSY + 2) @(negedge clk);
            #1;
            chk(pulses == p0, "R1 no pulse", 64'(pulses), 64'(p0));
            chk(bkp_count == CW'(cnt0), "R1 count kept", 64'(bkp_count), 64'(cnt0));
            chk(bkp_err == err0, "R1 err kept", 64'(bkp_err), 64'(err0));
            return;
        end
        chk(busy == 1'b1, "R1 start", 64'(busy), 64'd1);
        chk(bkp_err == 1'b0, "R7 err cleared", 64'(bkp_err), 64'd0);
        cyc = 0;
        while (busy === 1'b1 && cyc < NBUSY + 4) begin
            cyc++;
            if (cyc == drop) supply_ok = 1'b0;
            if (poke && cyc == 2) begin cmd_we = 1'b1; cmd_data = 8'h08; end
            if (poke && cyc == 3) cmd_we = 1'b0;
            @(negedge clk);
        end
        cmd_we = 1'b0;
        if (drop == 0) begin
            exp_cnt = (cnt0 == (1 << CW) - 1) ? cnt0 : cnt0 + 1;
            chk(cyc == NBUSY, "R3 busy length", 64'(cyc), 64'(NBUSY));
            chk(bkp_we == 1'b1, "R4 pulse", 64'(bkp_we), 64'd1);
            chk(bkp_data == pat(seed), "R2 snapshot", 64'(bkp_data), 64'(pat(seed)));
            chk(bkp_count == CW'(exp_cnt), "R8 count", 64'(bkp_count), 64'(exp_cnt));
        end else begin
            chk(cyc == drop, "R6 abort time", 64'(cyc), 64'(drop));
            chk(bkp_we == 1'b0, "R6 no pulse", 64'(bkp_we), 64'd0);
            chk(bkp_count == CW'(cnt0), "R6 count kept", 64'(bkp_count), 64'(cnt0));
            chk(bkp_err == 1'b1, "R6 err set", 64'(bkp_err), 64'd1);
            supply_ok = 1'b1;
        end
        @(negedge clk);
        #1;
        chk(bkp_we == 1'b0, "R4 single pulse", 64'(bkp_we), 64'd0);
        chk(pulses == p0 + (drop == 0 ? 1 : 0), "R5 pulse total", 64'(pulses), 64'(p0 + (drop == 0 ? 1 : 0)));
        chk(busy == 1'b0, "R5 no restart", 64'(busy), 64'd0);
        if (drop != 0) chk(bkp_err == 1'b1, "R7 err held", 64'(bkp_err), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && bkp_we == 1'b0 && bkp_err == 1'b0, "R10 flags", {61'd0, busy, bkp_we, bkp_err}, 64'd0);
        chk(bkp_count == '0, "R10 count", 64'(bkp_count), 64'd0);
        chk(bkp_data == '0, "R10 data", 64'(bkp_data), 64'd0);
        rst_n = 1'b1;
        for (int v = 0; v < 8; v++)
            run_req(VEC[v][31:24], int'(VEC[v][23:20]), VEC[v][16], VEC[v][15:0]);
        // R7: non-backup write after an abort leaves the error set
        run_req(8'h08, 2, 1'b0, 16'h0101);
        run_req(8'hF7, 0, 1'b0, 16'h0202);
        chk(bkp_err == 1'b1, "R7 err survives other write", 64'(bkp_err), 64'd1);
        // R9: drive the counter past its top
        for (int k = 0; k < 14; k++) run_req(8'h08, 0, 1'b0, 16'(k * 37));
        chk(bkp_count == '1, "R9 saturated", 64'(bkp_count), 64'((1 << CW) - 1));
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule